// File: doc/BRIEF.md
# Reset-Gated Memory Chip-Enable with Write Completion

This block sits between a memory controller's active-low chip-enable and the memory device. While the system supervisor holds reset deasserted, the enable passes straight through with no added register stage. While reset is asserted, the output is held high so that no access can reach the memory during power-up, brownout or power-down.

The cut-off is not abrupt when an access is in flight. If the chip-enable is low at the moment reset asserts, the gate stays open so the current write can finish. It closes when the enable returns high or when a grace window of `GRACE_CYC` clock cycles ends, whichever comes first. After it closes, it stays closed until reset deasserts. A status flag tells whether the gate is passing the enable in the current cycle.

The supervisor reset input `sys_rst` is expected to be synchronous to `clk`. The block's own flops use the asynchronous active-low `rst_n`.

Top module: `cegate_top`

## Requirements
- R1: While `sys_rst` is low and was also low at the previous clock edge, `mem_ce_out_n` equals `mem_ce_in_n` in the same cycle.
- R2: If `mem_ce_in_n` is high in the first cycle in which `sys_rst` is high, `mem_ce_out_n` is high in that cycle and `gate_open` is 0.
- R3: If `mem_ce_in_n` is low in the first cycle in which `sys_rst` is high, `mem_ce_out_n` stays low while the input stays low, for at most `GRACE_CYC` cycles counted from that first cycle. It goes high in the first cycle in which the input is high or the window has run out.
- R4: Once the gate has closed during a reset interval, `mem_ce_out_n` stays high and `gate_open` stays 0 until `sys_rst` goes low, even if `mem_ce_in_n` goes low again.
- R5: While `rst_n` is low, and afterwards until the first clock edge at which `sys_rst` is sampled low, the gate is closed: `mem_ce_out_n` is 1 and `gate_open` is 0.
- R6: `gate_open` is 1 exactly when `mem_ce_out_n` is driven from `mem_ce_in_n`, and 0 when the output is forced high.
- R7: Any low period of `sys_rst` clears the grace window, so the next reset assertion that arrives during an active access gets a full `GRACE_CYC` cycles, no matter how much of an earlier window was used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| sys_rst | input | 1 | Supervisor reset state, 1 = reset asserted, synchronous to clk |
| mem_ce_in_n | input | 1 | Active-low chip-enable from the memory controller |
| mem_ce_out_n | output | 1 | Gated active-low chip-enable to the memory |
| gate_open | output | 1 | 1 while the enable is being passed through |

## Verification
The pass-through path is driven with an alternating enable, long lows and long highs while reset is deasserted. This shows whether the output is truly combinational, or whether it lags or inverts the input. Reset is asserted in three ways: with the enable idle high, with the enable low and then released early, and with the enable held low past the window. These separate an immediate cut-off, an early close on the rising enable, and a close on timeout, and the low-cycle count is checked against `GRACE_CYC`. A partly used window followed by a one-cycle reset release checks that each new reset event starts a fresh window. Re-lowering the enable after the gate has closed checks that the gate stays closed.

// File: rtl/cegate_pkg.sv
package cegate_pkg;

  typedef enum logic [1:0] {
    GS_PASS  = 2'd0,
    GS_GRACE = 2'd1,
    GS_SHUT  = 2'd2
  } gate_state_t;

endpackage

// File: rtl/cegate_grace_timer.sv
module cegate_grace_timer #(
  parameter int GRACE_CYC = 3750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(GRACE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GRACE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == LAST);

  always_comb begin
    cnt_en = clear || load || (run && !expired);
    if (clear)     cnt_d = '0;
    else if (load) cnt_d = CW'(1);
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("grace counter past limit"); // R3

endmodule

// File: rtl/cegate_ctrl.sv
module cegate_ctrl
  import cegate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic ce_in_n,
  input  logic expired,
  output logic tmr_clear,
  output logic tmr_load,
  output logic tmr_run,
  output logic pass_en
);

  gate_state_t state_q;
  gate_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GS_PASS: begin
        if (sys_rst) state_d = ce_in_n ? GS_SHUT : GS_GRACE;
      end
      GS_GRACE: begin
        if (!sys_rst)                state_d = GS_PASS;
        else if (ce_in_n || expired) state_d = GS_SHUT;
      end
      GS_SHUT: begin
        if (!sys_rst) state_d = GS_PASS;
      end
      default: state_d = GS_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_SHUT;
    else        state_q <= state_d;
  end

  always_comb begin
    pass_en   = (state_q != GS_SHUT) && (!sys_rst || !ce_in_n);
    tmr_clear = !sys_rst;
    tmr_load  = (state_q == GS_PASS) && sys_rst && !ce_in_n;
    tmr_run   = (state_q == GS_GRACE) && sys_rst;
  end

  AST_SHUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_SHUT) && sys_rst |=> (state_q == GS_SHUT)) else $error("gate reopened in reset"); // R4

endmodule

// File: rtl/cegate_top.sv
module cegate_top #(
  parameter int GRACE_CYC = 3750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic mem_ce_in_n,
  output logic mem_ce_out_n,
  output logic gate_open
);

  logic tmr_clear;
  logic tmr_load;
  logic tmr_run;
  logic expired;
  logic pass_en;

  initial begin
    if (GRACE_CYC < 2) $error("GRACE_CYC must be at least 2");
  end

  cegate_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst   (sys_rst),
    .ce_in_n   (mem_ce_in_n),
    .expired   (expired),
    .tmr_clear (tmr_clear),
    .tmr_load  (tmr_load),
    .tmr_run   (tmr_run),
    .pass_en   (pass_en)
  );

  cegate_grace_timer #(.GRACE_CYC(GRACE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .load    (tmr_load),
    .run     (tmr_run),
    .expired (expired)
  );

  assign mem_ce_out_n = pass_en ? mem_ce_in_n : 1'b1;
  assign gate_open    = pass_en;

  AST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst && $past(!sys_rst) && $past(rst_n) |-> (mem_ce_out_n == mem_ce_in_n)) else $error("output not following"); // R1

  AST_IDLE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) && mem_ce_in_n |-> mem_ce_out_n && !gate_open) else $error("idle cut-off late"); // R2

  AST_RISE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst && $past(sys_rst) && $past(mem_ce_in_n) && $past(rst_n) |-> !gate_open) else $error("gate open after enable rose"); // R3

  AST_STAY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst && $past(sys_rst) && $past(!gate_open) |-> mem_ce_out_n && !gate_open) else $error("output left high state in reset"); // R4

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_out_n |-> gate_open) else $error("low output with gate closed"); // R6

endmodule

// File: tb/cegate_top_test.sv
`timescale 1ns/1ps
module cegate_top_test;

  localparam int GRACE = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic sys_rst;
  logic ce_in_n;
  logic ce_out_n;
  logic gate_open;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cegate_top #(.GRACE_CYC(GRACE)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_rst      (sys_rst),
    .mem_ce_in_n  (ce_in_n),
    .mem_ce_out_n (ce_out_n),
    .gate_open    (gate_open)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns later
  task automatic drive(input logic r, input logic ce);
    @(negedge clk);
    sys_rst = r;
    ce_in_n = ce;
    #1;
  endtask

  task automatic t_powerup();
    rst_n = 1'b0; sys_rst = 1'b1; ce_in_n = 1'b0;
    #11;
    chk("R5", "out in rst_n", int'(ce_out_n), 1);
    chk("R5", "flag in rst_n", int'(gate_open), 0);
    drive(1'b1, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, i[0]);
      chk("R5", "out in hold-off", int'(ce_out_n), 1);
    end
    drive(1'b0, 1'b0);
    chk("R5", "still closed before edge", int'(ce_out_n), 1);
    drive(1'b0, 1'b0);
    chk("R5", "open after release", int'(ce_out_n), 0);
  endtask

  task automatic t_follow();
    logic [15:0] pat = 16'b1010_0011_1100_0110;
    for (int i = 0; i < 16; i++) begin
      drive(1'b0, pat[i]);
      chk("R1", "pass-through", int'(ce_out_n), int'(pat[i]));
      chk("R6", "flag while passing", int'(gate_open), 1);
    end
  endtask

  task automatic t_idle_cut();
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    chk("R2", "out at reset rise", int'(ce_out_n), 1);
    chk("R2", "flag at reset rise", int'(gate_open), 0);
    drive(1'b1, 1'b0);
    chk("R4", "out after relow", int'(ce_out_n), 1);
    chk("R6", "flag closed", int'(gate_open), 0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic t_early_close();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      chk("R3", "grace holds low", int'(ce_out_n), 0);
      drive(1'b1, 1'b0);
    end
    drive(1'b1, 1'b1);
    chk("R3", "close on rise", int'(ce_out_n), 1);
    for (int i = 0; i < 30; i++) drive(1'b1, 1'b0);
    chk("R4", "stays closed", int'(ce_out_n), 1);
    chk("R4", "flag stays 0", int'(gate_open), 0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic count_window(input string req);
    int lows = 0;
    int first_hi = -1;
    drive(1'b1, 1'b0);
    for (int i = 0; i < 2 * GRACE; i++) begin
      if (!ce_out_n) lows++;
      else if (first_hi < 0) first_hi = i;
      drive(1'b1, 1'b0);
    end
    chk(req, "low cycles", lows, GRACE);
    chk(req, "first high cycle", first_hi, GRACE);
  endtask

  task automatic t_timeout();
    drive(1'b0, 1'b0);
    count_window("R3");
    drive(1'b0, 1'b0);
  endtask

  task automatic t_fresh();
    drive(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    chk("R7", "follows on brief release", int'(ce_out_n), 0);
    count_window("R7");
    drive(1'b0, 1'b1);
  endtask

  initial begin
    t_powerup();
    t_follow();
    t_idle_cut();
    t_early_close();
    t_timeout();
    t_fresh();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run hung actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule